// File: doc/BRIEF.md
# Three-Initiator Ordered Memory Arbiter

This block lets three initiators share a single memory request port. None of them has to handle contention. In every cycle where at least one initiator is asking and there is room to track the request, exactly one request is picked and sent to memory in that same cycle, so no idle cycle is inserted. Selection uses rotating priority. The initiator granted most recently drops to the lowest rank, so a waiting initiator is served within a few cycles.

Each request beat carries an address and a 256-bit data word. For every read that is committed, the block keeps the two-bit identity of the issuing initiator in a small queue. Memory returns read beats in issue order. Each beat is sent to the initiator at the head of the queue, and that entry is removed. Writes expect no response and are never queued. When the queue is full, new grants wait until a response frees an entry. A response arriving in the same cycle counts as freeing one.

Top module: `tri_ordered_arb`

## Requirements
- R1: After reset there are no grants and no response strobes. The first time all three initiators request, initiator 0 wins, because initiator 2 counts as the last one granted.
- R2: When any initiator requests and the tracking queue has room, `mem_valid` rises in that same cycle. Exactly one grant bit is set, and only for a requesting initiator. With no request, `mem_valid` and all grant bits are 0.
- R3: Priority rotates. The candidates are searched in the order last+1, last+2, last (modulo 3), where "last" is the most recently granted initiator.
- R4: An initiator that holds its request is granted within three cycles, not counting cycles stalled on a full queue.
- R5: While `mem_valid` is 1, `mem_write`, `mem_addr` and `mem_wdata` equal the granted initiator's fields. Initiator i occupies bits [i*ADDR_W +: ADDR_W] of `req_addr` and bits [i*DATA_W +: DATA_W] of `req_wdata`.
- R6: Only reads (`req_write`=0) record their initiator ID. Writes do not change the order of routed responses.
- R7: On each `rsp_valid` beat, exactly one `rd_valid` bit is set, the one for the oldest outstanding read, and `rd_data` equals `rsp_rdata`.
- R8: With DEPTH reads outstanding and no response in the cycle, nothing is granted. If a response arrives in that same cycle, a grant may proceed.
- R9: A single active initiator gets one request per cycle for reads, writes and any interleaving of the two, provided the queue does not fill.
- R10: Request and response data paths are 256 bits wide end to end, with every bit carried unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 3 | Per-initiator request pending, held until granted |
| req_write | input | 3 | Per-initiator request is a write (1) or read (0) |
| req_addr | input | 3*ADDR_W | Packed per-initiator addresses |
| req_wdata | input | 3*DATA_W | Packed per-initiator write data |
| req_grant | output | 3 | One-hot grant, same cycle as request |
| mem_valid | output | 1 | Request committed to memory this cycle |
| mem_write | output | 1 | Committed request is a write |
| mem_addr | output | ADDR_W | Committed address |
| mem_wdata | output | DATA_W | Committed write data |
| rsp_valid | input | 1 | In-order read response beat from memory |
| rsp_rdata | input | DATA_W | Read response data |
| rd_valid | output | 3 | Per-initiator response strobe |
| rd_data | output | DATA_W | Response data, shared by all initiators |

## Verification
The bench runs one initiator with reads and writes interleaved back to back. A design that inserted a bubble, or that queued writes, would drop `mem_valid` or send a later response to the wrong initiator. Partial request masks check the rotation order. A design that used fixed priority, or that did not move the winner to the bottom, picks the wrong initiator there, and under continuous contention it makes one initiator wait longer than three cycles. The queue is filled to capacity to check that grants stop, and that a response in the same cycle releases them; an off-by-one in the full test would grant into a full queue or stall one entry early.

// File: rtl/tri_arb_pkg.sv
package tri_arb_pkg;
  localparam int unsigned NUM_INIT = 3;
  localparam int unsigned ID_W     = 2;

  typedef logic [ID_W-1:0]     init_id_t;
  typedef logic [NUM_INIT-1:0] init_vec_t;

  // Rotating search starting just after the last winner.
  function automatic init_id_t rr_next(input init_vec_t req, input init_id_t last);
    init_id_t    pick;
    logic        found;
    int unsigned cand;
    pick  = last;
    found = 1'b0;
    for (int unsigned k = 1; k <= NUM_INIT; k++) begin
      cand = (32'(last) + k) % NUM_INIT;
      if (!found && req[cand[ID_W-1:0]]) begin
        pick  = cand[ID_W-1:0];
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  function automatic init_vec_t id_to_onehot(input init_id_t id);
    return init_vec_t'(1) << id;
  endfunction
endpackage

// File: rtl/tri_rr_arbiter.sv
module tri_rr_arbiter
  import tri_arb_pkg::*;
#(
  parameter int unsigned MAX_WAIT = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  init_vec_t req,
  input  logic      allow,
  output init_vec_t gnt,
  output init_id_t  gnt_idx,
  output logic      gnt_any
);
  localparam int unsigned WCNT_W = $clog2(MAX_WAIT + 2);

  init_id_t last_q;

  assign gnt_any = allow && (|req);
  assign gnt_idx = rr_next(req, last_q);
  assign gnt     = gnt_any ? id_to_onehot(gnt_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= init_id_t'(NUM_INIT - 1);
    else if (gnt_any) last_q <= gnt_idx;
  end

  // Wait-length observers, one per initiator
  logic [WCNT_W-1:0] wait_q [NUM_INIT];
  for (genvar gi = 0; gi < NUM_INIT; gi++) begin : g_wait
    always_ff @(posedge clk) begin
      if (!rst_n)                       wait_q[gi] <= '0;
      else if (!req[gi] || gnt[gi])     wait_q[gi] <= '0;
      else if (allow)                   wait_q[gi] <= wait_q[gi] + 1'b1;
    end

    // R4
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(wait_q[gi]) < MAX_WAIT);
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2
  grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  // R3
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && ((req & ~id_to_onehot(last_q)) != '0)) |-> (gnt_idx != last_q));
endmodule

// File: rtl/tri_order_fifo.sv
module tri_order_fifo
  import tri_arb_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  init_id_t push_id,
  input  logic     pop,
  output init_id_t head_id,
  output logic     empty,
  output logic     full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  init_id_t          slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;

  assign empty   = (cnt_q == '0);
  assign full    = (32'(cnt_q) == DEPTH);
  assign head_id = slot_q[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= ptr_inc(wr_q);
      if (pop)  rd_q <= ptr_inc(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= push_id;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |-> !push);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);

  // R6
  count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(cnt_q));
endmodule

// File: rtl/tri_rsp_router.sv
module tri_rsp_router
  import tri_arb_pkg::*;
#(
  parameter int unsigned DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  init_id_t          head_id,
  output init_vec_t         rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  assign rd_valid = rsp_valid ? id_to_onehot(head_id) : '0;
  assign rd_data  = rsp_rdata;

  // R7
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot(rd_valid));

  // R7
  route_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rd_valid == '0));
endmodule

// File: rtl/tri_ordered_arb.sv
module tri_ordered_arb
  import tri_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 256,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_INIT-1:0]          req_valid,
  input  logic [NUM_INIT-1:0]          req_write,
  input  logic [NUM_INIT*ADDR_W-1:0]   req_addr,
  input  logic [NUM_INIT*DATA_W-1:0]   req_wdata,
  output logic [NUM_INIT-1:0]          req_grant,
  output logic                         mem_valid,
  output logic                         mem_write,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic                         rsp_valid,
  input  logic [DATA_W-1:0]            rsp_rdata,
  output logic [NUM_INIT-1:0]          rd_valid,
  output logic [DATA_W-1:0]            rd_data
);
  // Named internal events
  init_id_t  gnt_idx;
  logic      gnt_any;
  logic      trk_full, trk_empty;
  logic      trk_push, trk_pop;
  logic      grant_allow;
  init_id_t  trk_head;

  assign trk_pop     = rsp_valid;
  assign grant_allow = !trk_full || trk_pop;
  assign trk_push    = gnt_any && !req_write[gnt_idx];

  tri_rr_arbiter #(.MAX_WAIT(3)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_valid),
    .allow   (grant_allow),
    .gnt     (req_grant),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  tri_order_fifo #(.DEPTH(DEPTH)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (trk_push),
    .push_id (gnt_idx),
    .pop     (trk_pop),
    .head_id (trk_head),
    .empty   (trk_empty),
    .full    (trk_full)
  );

  tri_rsp_router #(.DATA_W(DATA_W)) u_rte (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .head_id   (trk_head),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  always_comb begin
    mem_valid = gnt_any;
    mem_write = gnt_any && req_write[gnt_idx];
    mem_addr  = req_addr[32'(gnt_idx)*ADDR_W +: ADDR_W];
    mem_wdata = req_wdata[32'(gnt_idx)*DATA_W +: DATA_W];
  end

  // R2
  no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_valid) && !trk_full) |-> mem_valid);

  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_full && !rsp_valid) |-> !mem_valid);

  // R7
  rsp_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !trk_empty);

  // R6
  write_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> !trk_push);
endmodule

// File: tb/tri_ordered_arb_bench.sv
module tri_ordered_arb_bench;
  localparam int AW = 32;
  localparam int DW = 256;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]      req_valid = '0, req_write = '0;
  logic [3*AW-1:0] req_addr = '0;
  logic [3*DW-1:0] req_wdata = '0;
  logic [2:0]      req_grant;
  logic            mem_valid, mem_write;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata;
  logic            rsp_valid = 1'b0;
  logic [DW-1:0]   rsp_rdata = '0;
  logic [2:0]      rd_valid;
  logic [DW-1:0]   rd_data;

  tri_ordered_arb #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_tri_ordered_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int mdl_last = 2;
  int mdl_q[$];
  int waits[3];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic int pick(input logic [2:0] rq, input int last);
    for (int k = 1; k <= 3; k++) begin
      if (rq[(last + k) % 3]) return (last + k) % 3;
    end
    return -1;
  endfunction

  // One cycle: drive, check combinational outputs, advance model.
  task automatic step(input logic [2:0] rq, input logic [2:0] wr, input bit rsp, input string tag);
    int g, tgt;
    bit room;
    logic [DW-1:0] rdat;
    @(negedge clk);
    cyc++;
    req_valid = rq;
    req_write = wr;
    for (int i = 0; i < 3; i++) begin
      req_addr[i*AW +: AW]  = 32'h1000_0000 * (i + 1) + cyc;
      req_wdata[i*DW +: DW] = {8{32'hA500_0000 | (i << 16) | cyc}};
    end
    rdat      = {8{32'hD000_0000 | cyc}} ^ {DW{cyc[0]}};
    rsp_valid = rsp;
    rsp_rdata = rdat;
    #1;
    room = (mdl_q.size() < DEPTH) || rsp;
    g = room ? pick(rq, mdl_last) : -1;
    chk(mem_valid == (g >= 0), tag, "mem_valid", DW'(mem_valid), DW'(g >= 0));
    chk(req_grant == ((g >= 0) ? 3'(1 << g) : 3'b0), tag, "grant",
        DW'(req_grant), (g >= 0) ? DW'(1 << g) : '0);
    if (g >= 0) begin
      // R5 R10
      chk(mem_write == wr[g] && mem_addr == 32'h1000_0000 * (g + 1) + cyc, "R5",
          "write/addr", DW'(mem_addr), DW'(32'h1000_0000 * (g + 1) + cyc));
      chk(mem_wdata == {8{32'hA500_0000 | (g << 16) | cyc}}, "R10", "wdata",
          mem_wdata, {8{32'hA500_0000 | (g << 16) | cyc}});
    end
    if (rsp) begin
      tgt = mdl_q[0];
      // R7
      chk(rd_valid == 3'(1 << tgt) && rd_data == rdat, "R7", "rd_valid/data",
          DW'(rd_valid), DW'(1 << tgt));
    end else begin
      chk(rd_valid == 3'b0, "R7", "rd_valid idle", DW'(rd_valid), '0);
    end
    for (int i = 0; i < 3; i++) begin
      if (rq[i] && g != i && room) waits[i]++;
      else if (!rq[i] || g == i) waits[i] = 0;
      if (rq[i]) chk(waits[i] <= 3, "R4", "wait length", DW'(waits[i]), DW'(3));
    end
    if (rsp) void'(mdl_q.pop_front());
    if (g >= 0) begin
      mdl_last = g;
      if (!wr[g]) mdl_q.push_back(g);
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(mem_valid == 1'b0 && req_grant == 3'b0, "R1", "idle after reset", DW'(req_grant), '0);
    chk(rd_valid == 3'b0, "R1", "rd idle after reset", DW'(rd_valid), '0);
    step(3'b111, 3'b111, 0, "R1");   // initiator 0 must win first
  endtask

  task automatic t_stream();
    // R9: single initiator, reads and writes interleaved, no bubble
    for (int i = 0; i < 10; i++)
      step(3'b010, (i % 3 == 1) ? 3'b010 : 3'b000, mdl_q.size() >= 2, "R9");
    step(3'b000, 3'b000, 0, "R2");
    while (mdl_q.size() > 0) step(3'b000, 3'b000, 1, "R7");
  endtask

  task automatic t_rotate();
    step(3'b101, 3'b111, 0, "R3");
    step(3'b101, 3'b111, 0, "R3");
    step(3'b011, 3'b111, 0, "R3");
    step(3'b110, 3'b111, 0, "R3");
    step(3'b111, 3'b111, 0, "R3");
    step(3'b100, 3'b111, 0, "R3");
    step(3'b111, 3'b111, 0, "R3");
  endtask

  task automatic t_fair();
    for (int i = 0; i < 12; i++) step(3'b111, 3'b111, 0, "R4");
  endtask

  task automatic t_order();
    // R6: reads from 2,0,1 with writes between; responses in read order
    step(3'b100, 3'b000, 0, "R6");
    step(3'b001, 3'b001, 0, "R6");
    step(3'b001, 3'b000, 0, "R6");
    step(3'b010, 3'b000, 0, "R6");
    step(3'b100, 3'b100, 1, "R6");
    step(3'b000, 3'b000, 1, "R6");
    step(3'b000, 3'b000, 1, "R6");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) step(3'b001 << (i % 3), 3'b000, 0, "R8");
    step(3'b111, 3'b000, 0, "R8");    // full, no response: no grant
    step(3'b111, 3'b111, 0, "R8");    // writes also held
    step(3'b111, 3'b000, 1, "R8");    // response frees room same cycle
    while (mdl_q.size() > 0) step(3'b000, 3'b000, 1, "R8");
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_stream();
    t_rotate();
    t_fair();
    t_order();
    t_full();
    step(3'b000, 3'b000, 0, "R2");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule